// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register File

This block holds the software-visible control and status registers for every channel of a DMA controller. Each channel owns two banks, one for the write direction and one for the read direction, and every bank carries its own enable, start request, 64-bit list pointer, cycle-sync bits, linked-list mode bit, engine state and done/abort interrupt status. Software reaches the banks over a simple 32-bit register bus. Writes take effect on the clock edge. Reads are combinational from the address.

The channel engines sit beside the block. Each engine gets its bank's enable, a one-cycle start pulse, the list pointer, the cycle-sync bits and the linked-list mode bit. It reports done and abort events and a two-bit running state. Each bank turns its sticky done/abort status into a local interrupt line and a remote interrupt line. A mask bit and an enable bit per line, per event, gate each of them.

Top module: `dma_chreg_file`

## Requirements
- R1: Bank b = 2*channel + direction (direction 0 = write, 1 = read) sits at byte address channel*0x200 + direction*0x100. Inside a bank, the enable register at 0x00 holds bit 0. List pointer low at 0x10 and high at 0x14 hold 32 bits each. Cycle sync at 0x18 holds bits [1:0]. Control at 0x34 holds bit 0 (linked-list mode). Unused bits read 0. The stored values drive chan_en, list_ptr, cyc_sync and ll_mode of that bank.
- R2: A write with bit 0 set to the start register at 0x04 makes chan_start of that bank high for exactly the one cycle after the write edge. A write with bit 0 clear starts nothing. The start register reads 0.
- R3: The state register at 0x80 reads the bank's eng_state in bits [1:0].
- R4: A done event sets interrupt status bit 0 and an abort event sets bit 2, both readable at 0x84. Each bit stays set until it is cleared.
- R5: Writing 1 to bit 0 or bit 2 of the clear register at 0x8C clears the done or abort status bit. A zero bit leaves it alone. An event in the same cycle as the clear wins, and the bit stays set. The clear register reads 0.
- R6: The interrupt setup register at 0x88 stores bits 0, 2, 3, 4, 5 and 6. Bit 1 and bits above 6 read 0.
- R7: irq_loc of a bank is high when (done status, setup bit 0 clear, setup bit 4 set) or (abort status, setup bit 2 clear, setup bit 6 set).
- R8: irq_rem of a bank is high when (done status, setup bit 0 clear, setup bit 3 set) or (abort status, setup bit 2 clear, setup bit 5 set).
- R9: An access is unmapped if its channel index is NUM_CH or higher, if an address bit above the bank field is set, or if its in-bank offset is none of the ten listed offsets (misaligned offsets included). Writes to unmapped addresses change nothing. Reads of them return 0.
- R10: While rst_n is low every register is zero, and so every output is zero.
- R11: Writes to the state register (0x80) and the interrupt status register (0x84) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eng_done | input | 2*NUM_CH | Per-bank done event |
| eng_abort | input | 2*NUM_CH | Per-bank abort event |
| eng_state | input | 4*NUM_CH | Per-bank running state, 2 bits each |
| chan_en | output | 2*NUM_CH | Per-bank channel enable |
| chan_start | output | 2*NUM_CH | Per-bank one-cycle start pulse |
| ll_mode | output | 2*NUM_CH | Per-bank linked-list mode |
| cyc_sync | output | 4*NUM_CH | Per-bank cycle-sync bits, 2 each |
| list_ptr | output | 128*NUM_CH | Per-bank 64-bit list pointer |
| irq_loc | output | 2*NUM_CH | Per-bank local interrupt |
| irq_rem | output | 2*NUM_CH | Per-bank remote interrupt |

## Verification
Several properties are checked on every cycle:
- at most one start pulse is high, and only after a write;
- an interrupt line rises only after an event or a write, and falls only after a write;
- the enable outputs move only after a write;
- the write-only and misaligned offsets read zero.

The scenarios are needed for the rest: the mask-versus-enable combinations, event-beats-clear priority, unmapped channel rejection and read-only status writes. A behavioural model of every bank follows them and is compared cycle by cycle under directed and random traffic.

// File: rtl/dmareg_pkg.sv
`timescale 1ns/1ps
package dmareg_pkg;
   localparam logic [7:0] OFF_ENABLE  = 8'h00;
   localparam logic [7:0] OFF_DBELL   = 8'h04;
   localparam logic [7:0] OFF_LPTR_LO = 8'h10;
   localparam logic [7:0] OFF_LPTR_HI = 8'h14;
   localparam logic [7:0] OFF_CYC     = 8'h18;
   localparam logic [7:0] OFF_CTRL    = 8'h34;
   localparam logic [7:0] OFF_STATE   = 8'h80;
   localparam logic [7:0] OFF_ISTAT   = 8'h84;
   localparam logic [7:0] OFF_ISETUP  = 8'h88;
   localparam logic [7:0] OFF_ICLR    = 8'h8C;

   // setup register bit positions
   localparam int SU_DONE_MASK  = 0;
   localparam int SU_ABORT_MASK = 2;
   localparam int SU_REM_DONE   = 3;
   localparam int SU_LOC_DONE   = 4;
   localparam int SU_REM_ABORT  = 5;
   localparam int SU_LOC_ABORT  = 6;
   localparam logic [6:0] SU_WRITABLE = 7'h7D;

   function automatic logic off_mapped(input logic [7:0] off);
      return (off == OFF_ENABLE) || (off == OFF_DBELL) || (off == OFF_LPTR_LO) ||
             (off == OFF_LPTR_HI) || (off == OFF_CYC) || (off == OFF_CTRL) ||
             (off == OFF_STATE) || (off == OFF_ISTAT) || (off == OFF_ISETUP) ||
             (off == OFF_ICLR);
   endfunction
endpackage

// File: rtl/dmareg_dec.sv
`timescale 1ns/1ps
module dmareg_dec
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 12,
   localparam int NB     = 2 * NUM_CH,
   localparam int BANK_W = $clog2(NB)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [BANK_W-1:0] bank,
   output logic [7:0]        off
);
   logic upper_zero;

   assign off  = addr[7:0];
   assign bank = addr[8 +: BANK_W];

   generate
      if (ADDR_W > 8 + BANK_W) begin : g_upper
         assign upper_zero = (addr[ADDR_W-1:8+BANK_W] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign hit = upper_zero && (int'(bank) < NB) && off_mapped(off);
endmodule

// File: rtl/dmareg_bank.sv
`timescale 1ns/1ps
module dmareg_bank
   import dmareg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  off,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic        ev_done,
   input  logic        ev_abort,
   input  logic [1:0]  state,
   output logic        en,
   output logic        start,
   output logic        ll,
   output logic [1:0]  cyc,
   output logic [63:0] lptr,
   output logic        irq_l,
   output logic        irq_r
);
   logic [6:0] setup;
   logic       st_done, st_abort;
   logic       clr_done, clr_abort;

   assign clr_done  = wr_en && (off == OFF_ICLR) && wdata[SU_DONE_MASK];
   assign clr_abort = wr_en && (off == OFF_ICLR) && wdata[SU_ABORT_MASK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         start    <= 1'b0;
         ll       <= 1'b0;
         cyc      <= '0;
         lptr     <= '0;
         setup    <= '0;
         st_done  <= 1'b0;
         st_abort <= 1'b0;
      end else begin
         start <= wr_en && (off == OFF_DBELL) && wdata[0];
         if (wr_en) begin
            case (off)
               OFF_ENABLE:  en           <= wdata[0];
               OFF_LPTR_LO: lptr[31:0]   <= wdata;
               OFF_LPTR_HI: lptr[63:32]  <= wdata;
               OFF_CYC:     cyc          <= wdata[1:0];
               OFF_CTRL:    ll           <= wdata[0];
               OFF_ISETUP:  setup        <= wdata[6:0] & SU_WRITABLE;
               default: ;
            endcase
         end
         // an arriving event outranks a clear in the same cycle
         st_done  <= ev_done  | (st_done  & ~clr_done);
         st_abort <= ev_abort | (st_abort & ~clr_abort);
      end
   end

   always_comb begin
      irq_l = (st_done  && !setup[SU_DONE_MASK]  && setup[SU_LOC_DONE]) ||
              (st_abort && !setup[SU_ABORT_MASK] && setup[SU_LOC_ABORT]);
      irq_r = (st_done  && !setup[SU_DONE_MASK]  && setup[SU_REM_DONE]) ||
              (st_abort && !setup[SU_ABORT_MASK] && setup[SU_REM_ABORT]);
   end

   always_comb begin
      case (off)
         OFF_ENABLE:  rdata = {31'b0, en};
         OFF_LPTR_LO: rdata = lptr[31:0];
         OFF_LPTR_HI: rdata = lptr[63:32];
         OFF_CYC:     rdata = {30'b0, cyc};
         OFF_CTRL:    rdata = {31'b0, ll};
         OFF_STATE:   rdata = {30'b0, state};
         OFF_ISTAT:   rdata = {29'b0, st_abort, 1'b0, st_done};
         OFF_ISETUP:  rdata = {25'b0, setup};
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_chreg_file.sv
`timescale 1ns/1ps
module dma_chreg_file
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 12,
   localparam int NB     = 2 * NUM_CH,
   localparam int BANK_W = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NB-1:0]     eng_done,
   input  logic [NB-1:0]     eng_abort,
   input  logic [2*NB-1:0]   eng_state,
   output logic [NB-1:0]     chan_en,
   output logic [NB-1:0]     chan_start,
   output logic [NB-1:0]     ll_mode,
   output logic [2*NB-1:0]   cyc_sync,
   output logic [64*NB-1:0]  list_ptr,
   output logic [NB-1:0]     irq_loc,
   output logic [NB-1:0]     irq_rem
);
   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("NUM_CH must lie in 1..8");
      end
      if (ADDR_W < 8 + BANK_W) begin : g_bad_aw
         $error("ADDR_W too narrow for the bank field");
      end
   endgenerate

   logic              hit;
   logic [BANK_W-1:0] bank;
   logic [7:0]        off;
   logic [31:0]       bank_rd [NB];

   dmareg_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .addr(reg_addr), .hit(hit), .bank(bank), .off(off)
   );

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         logic sel_wr;
         assign sel_wr = reg_wr && hit && (int'(bank) == b);
         dmareg_bank u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .off(off),
            .wdata(reg_wdata), .rdata(bank_rd[b]),
            .ev_done(eng_done[b]), .ev_abort(eng_abort[b]),
            .state(eng_state[2*b +: 2]),
            .en(chan_en[b]), .start(chan_start[b]), .ll(ll_mode[b]),
            .cyc(cyc_sync[2*b +: 2]), .lptr(list_ptr[64*b +: 64]),
            .irq_l(irq_loc[b]), .irq_r(irq_rem[b])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NB; b++) begin
         if (hit && int'(bank) == b) reg_rdata = bank_rd[b];
      end
   end
endmodule

// File: rtl/dma_chreg_file_chk.sv
`timescale 1ns/1ps
module dma_chreg_file_chk #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 12,
   localparam int NB = 2 * NUM_CH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic [NB-1:0]     eng_done,
   input logic [NB-1:0]     eng_abort,
   input logic [NB-1:0]     chan_en,
   input logic [NB-1:0]     chan_start,
   input logic [NB-1:0]     irq_loc,
   input logic [NB-1:0]     irq_rem
);
   assert_start_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_start));

   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_start != '0) |-> $past(reg_wr && reg_wdata[0]));

   assert_wo_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[7:0] == 8'h04 || reg_addr[7:0] == 8'h8C) |-> (reg_rdata == '0));

   assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));

   assert_en_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chan_en) |-> $past(reg_wr));

   generate
      for (genvar b = 0; b < NB; b++) begin : g_irq
         assert_loc_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_loc[b]) |-> $past(eng_done[b] || eng_abort[b] || reg_wr));
         assert_rem_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_rem[b]) |-> $past(eng_done[b] || eng_abort[b] || reg_wr));
         assert_loc_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_loc[b]) |-> $past(reg_wr));
      end
   endgenerate
endmodule

bind dma_chreg_file dma_chreg_file_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
   .eng_abort(eng_abort), .chan_en(chan_en), .chan_start(chan_start),
   .irq_loc(irq_loc), .irq_rem(irq_rem)
);

// File: tb/sim_dma_chreg_file.sv
`timescale 1ns/1ps
module sim_dma_chreg_file;
   localparam int NUM_CH = 4;
   localparam int ADDR_W = 12;
   localparam int NB = 2 * NUM_CH;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [NB-1:0]     eng_done = '0, eng_abort = '0;
   logic [2*NB-1:0]   eng_state = '0;
   logic [NB-1:0]     chan_en, chan_start, ll_mode, irq_loc, irq_rem;
   logic [2*NB-1:0]   cyc_sync;
   logic [64*NB-1:0]  list_ptr;

   int tests = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dma_chreg_file #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
      .eng_abort(eng_abort), .eng_state(eng_state), .chan_en(chan_en),
      .chan_start(chan_start), .ll_mode(ll_mode), .cyc_sync(cyc_sync),
      .list_ptr(list_ptr), .irq_loc(irq_loc), .irq_rem(irq_rem)
   );

   // ---------------- behavioural reference ----------------
   bit          m_en[NB], m_st[NB], m_ll[NB], m_dn[NB], m_ab[NB];
   logic [1:0]  m_cyc[NB];
   logic [31:0] m_lo[NB], m_hi[NB];
   logic [6:0]  m_su[NB];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            m_en[b] = 0; m_st[b] = 0; m_ll[b] = 0; m_dn[b] = 0; m_ab[b] = 0;
            m_cyc[b] = 0; m_lo[b] = 0; m_hi[b] = 0; m_su[b] = 0;
         end
      end else begin
         int ch, b, o;
         for (int k = 0; k < NB; k++) m_st[k] = 0;
         ch = int'(reg_addr) / 512;
         b  = ch * 2 + int'(reg_addr[8]);
         o  = int'(reg_addr) % 256;
         if (reg_wr && ch < NUM_CH) begin
            if (o == 'h00) m_en[b] = reg_wdata[0];
            if (o == 'h04) m_st[b] = reg_wdata[0];
            if (o == 'h10) m_lo[b] = reg_wdata;
            if (o == 'h14) m_hi[b] = reg_wdata;
            if (o == 'h18) m_cyc[b] = reg_wdata[1:0];
            if (o == 'h34) m_ll[b] = reg_wdata[0];
            if (o == 'h88) m_su[b] = {reg_wdata[6:2], 1'b0, reg_wdata[0]};
            if (o == 'h8C) begin
               if (reg_wdata[0]) m_dn[b] = 0;
               if (reg_wdata[2]) m_ab[b] = 0;
            end
         end
         for (int k = 0; k < NB; k++) begin
            if (eng_done[k])  m_dn[k] = 1;
            if (eng_abort[k]) m_ab[k] = 1;
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a);
      int ch, b, o;
      ch = int'(a) / 512;
      b  = ch * 2 + int'(a[8]);
      o  = int'(a) % 256;
      if (ch >= NUM_CH) return 0;
      case (o)
         'h00: return {31'b0, m_en[b]};
         'h10: return m_lo[b];
         'h14: return m_hi[b];
         'h18: return {30'b0, m_cyc[b]};
         'h34: return {31'b0, m_ll[b]};
         'h80: return {30'b0, eng_state[2*b +: 2]};
         'h84: return {29'b0, m_ab[b], 1'b0, m_dn[b]};
         'h88: return {25'b0, m_su[b]};
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_irq(input int b, input bit remote);
      int dn_en, ab_en;
      dn_en = remote ? 3 : 4;
      ab_en = remote ? 5 : 6;
      return (m_dn[b] && !m_su[b][0] && m_su[b][dn_en]) ||
             (m_ab[b] && !m_su[b][2] && m_su[b][ab_en]);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // every-cycle comparison, between the active edge and the next input change
   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         for (int b = 0; b < NB; b++) begin
            check("R1", "chan_en",  chan_en[b], m_en[b]);
            check("R1", "ll_mode",  ll_mode[b], m_ll[b]);
            check("R1", "cyc_sync", cyc_sync[2*b +: 2], m_cyc[b]);
            check("R1", "list_ptr", list_ptr[64*b +: 64], {m_hi[b], m_lo[b]});
            check("R2", "chan_start", chan_start[b], m_st[b]);
            check("R7", "irq_loc", irq_loc[b], exp_irq(b, 0));
            check("R8", "irq_rem", irq_rem[b], exp_irq(b, 1));
         end
         check("R9", "reg_rdata", reg_rdata, exp_rd(reg_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, "read", reg_rdata, e);
   endtask

   task automatic pulse(input logic [NB-1:0] dn, input logic [NB-1:0] ab);
      @(negedge clk);
      eng_done = dn; eng_abort = ab;
      @(negedge clk);
      eng_done = '0; eng_abort = '0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R10: everything zero while reset is held
      #3;
      check("R10", "chan_en",  chan_en, 0);
      check("R10", "chan_start", chan_start, 0);
      check("R10", "irq_loc",  irq_loc | irq_rem, 0);
      check("R10", "list_ptr", list_ptr == '0, 1);
      #20;
      @(negedge clk) rst_n = 1'b1;

      // R1: register storage and outputs
      wr('h000, 32'h1);
      rd('h000, 32'h1, "R1");
      check("R1", "chan_en", chan_en, 8'h01);
      wr('h310, 32'hDEADBEEF);
      wr('h314, 32'h01234567);
      rd('h310, 32'hDEADBEEF, "R1");
      check("R1", "list_ptr bank3", list_ptr[64*3 +: 64], 64'h01234567DEADBEEF);
      wr('h218, 32'hFFFFFFFF);
      rd('h218, 32'h3, "R1");
      wr('h234, 32'hFFFFFFFF);
      rd('h234, 32'h1, "R1");
      check("R1", "ll_mode", ll_mode, 8'h04);

      // R2: start pulse
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 'h104; reg_wdata = 32'h1;
      @(negedge clk);
      reg_wr = 1'b0;
      check("R2", "start pulse", chan_start, 8'h02);
      @(negedge clk);
      check("R2", "start ends", chan_start, 8'h00);
      rd('h104, 32'h0, "R2");
      wr('h104, 32'h2);
      check("R2", "no start on bit0=0", chan_start, 8'h00);

      // R3: engine state readback, bank 5 = channel 2 read side
      @(negedge clk) eng_state[11:10] = 2'b11;
      rd('h580, 32'h3, "R3");

      // R6: setup writable bits
      wr('h088, 32'hFFFFFFFF);
      rd('h088, 32'h7D, "R6");
      wr('h088, 32'h10);

      // R4 / R7 / R8: done event on bank 0 with local done enable
      pulse(8'h01, 8'h00);
      rd('h084, 32'h1, "R4");
      check("R7", "irq_loc raised", irq_loc, 8'h01);
      check("R8", "irq_rem quiet", irq_rem, 8'h00);
      wr('h088, 32'h11);
      check("R7", "irq_loc masked", irq_loc, 8'h00);
      rd('h084, 32'h1, "R4");

      // R5: clear and event-wins priority
      wr('h08C, 32'h1);
      rd('h084, 32'h0, "R5");
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 'h08C; reg_wdata = 32'h1; eng_done = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0; eng_done = '0;
      rd('h084, 32'h1, "R5");
      wr('h08C, 32'h5);
      rd('h084, 32'h0, "R5");
      rd('h08C, 32'h0, "R5");

      // R8: remote abort on bank 1
      wr('h188, 32'h20);
      pulse(8'h00, 8'h02);
      check("R8", "irq_rem raised", irq_rem, 8'h02);
      check("R7", "irq_loc quiet", irq_loc, 8'h00);
      rd('h184, 32'h4, "R4");

      // R9: unmapped accesses
      wr('h040, 32'hFFFF);
      rd('h040, 32'h0, "R9");
      wr('h800, 32'h1);
      check("R9", "chan_en after ch4 write", chan_en, 8'h01);
      rd('h800, 32'h0, "R9");
      wr('h001, 32'h0);
      check("R9", "chan_en after misaligned write", chan_en, 8'h01);
      rd('h001, 32'h0, "R9");

      // R11: read-only registers
      wr('h184, 32'h0);
      rd('h184, 32'h4, "R11");
      wr('h080, 32'h3);
      rd('h080, 32'h0, "R11");

      // mixed random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         reg_wr    = ($urandom % 3) == 0;
         reg_addr  = ADDR_W'($urandom);
         if ($urandom % 4 != 0) begin
            case ($urandom % 10)
               0: reg_addr[7:0] = 8'h00; 1: reg_addr[7:0] = 8'h04;
               2: reg_addr[7:0] = 8'h10; 3: reg_addr[7:0] = 8'h14;
               4: reg_addr[7:0] = 8'h18; 5: reg_addr[7:0] = 8'h34;
               6: reg_addr[7:0] = 8'h80; 7: reg_addr[7:0] = 8'h84;
               8: reg_addr[7:0] = 8'h88; default: reg_addr[7:0] = 8'h8C;
            endcase
         end
         reg_wdata = $urandom;
         for (int b = 0; b < NB; b++) begin
            eng_done[b]  = ($urandom % 8) == 0;
            eng_abort[b] = ($urandom % 8) == 0;
         end
         eng_state = 16'($urandom);
      end
      @(negedge clk);
      reg_wr = 1'b0; eng_done = '0; eng_abort = '0;
      @(negedge clk);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule